// File: doc/BRIEF.md
# Eight-Channel ADC Scan Sequencer

This block is the master side of a serial link to a 10-bit successive-approximation converter. The converter delivers 12 result bits per conversion: 10 data bits and 2 sub-LSB bits. On each trigger the sequencer runs one scan. A scan is one chip-select frame that converts every channel in ascending order, single-ended and unipolar, with the converter clocked by the serial clock.

Each control byte goes out while the previous result is still being shifted in. This gives one conversion per 16 serial clocks. Two trailing zero bytes carry out the last result. Every result goes into a small result memory at the address equal to its channel number, and a one-cycle done pulse follows the last write.

A scan can be configured to leave the converter asleep afterwards. The next scan then wakes it first: it sends a throw-away conversion, then keeps the link quiet for a fixed number of serial-clock periods, then starts the real scan. A scan is started either by a start pulse or by an internal periodic timer.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is held and directly after it, `spi_cs_n_o` is 1, `spi_sclk_o` is 0, `spi_mosi_o` is 0 and `scan_done_o` is 0.
- R2: `spi_sclk_o` idles low and stays low whenever `spi_cs_n_o` is 1. `spi_mosi_o` is 0 whenever `spi_cs_n_o` is 1. Inside a frame, `spi_mosi_o` changes only together with a falling `spi_sclk_o`. Each serial-clock period is `2*HALF_DIV` system cycles, low half first.
- R3: A control byte is sent MSB first, and its bit positions are decoded by the converter. Bit 7 is the start bit (1). Bits 6:4 hold the channel number in binary. Bit 3 is 1 (unipolar). Bit 2 is 1 (single-ended). Bits 1:0 are the power code: 11 means stay powered with the serial clock running the conversion, and 01 means power down after this conversion.
- R4: A scan frame lasts `16*N_CH+8` serial-clock periods. Counting periods from 0, the control byte for channel n occupies periods 16n to 16n+7, for channels 0 to N_CH-1 in that order. Every other period carries 0, including the two trailing bytes.
- R5: The sequencer samples `spi_miso_i` on each rising serial clock. The result for channel n is the 12 bits in periods 16n+9 to 16n+20, MSB first, and it is stored at address n. `rd_data_o` shows the stored word at `rd_addr_i` in the same cycle.
- R6: `scan_done_o` is a single-cycle pulse. It fires in the cycle `spi_cs_n_o` rises at the end of a scan frame, which is after the last channel has been written.
- R7: If the sleep setting latched at the start of a scan is 1, the last control byte of that scan carries power code 01. Every other control byte carries 11.
- R8: A scan that follows a scan which ended with power code 01 is preceded by a wake-up. The wake-up is a 24-period frame whose only control byte is channel 0 with code 11, and whose result is discarded. After it, `spi_cs_n_o` stays high for exactly `WAKE_IDLE` serial-clock periods before the scan frame begins.
- R9: `sleep_cfg_i` is sampled only in the cycle a scan is accepted. A change during a scan alters neither that scan's control bytes nor whether the next scan wakes the converter first.
- R10: A scan is accepted on a `start_i` pulse, or every `TIMER_CYCLES` cycles while `timer_en_i` is 1. A trigger that arrives while a scan or wake-up is in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle scan request |
| timer_en_i | input | 1 | Enables the periodic scan timer |
| sleep_cfg_i | input | 1 | 1 leaves the converter asleep after the scan |
| rd_addr_i | input | AW (3) | Result memory read address (channel) |
| rd_data_o | output | RES_W (12) | Stored result for `rd_addr_i` |
| scan_done_o | output | 1 | One-cycle pulse after the last result is written |
| spi_sclk_o | output | 1 | Serial clock to the converter |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Control bits to the converter |
| spi_miso_i | input | 1 | Result bits from the converter |

## Verification
The bench builds the block with eight channels, 12-bit results, `HALF_DIV=2` and the full 75-period wake-up wait. With these values a conversion slot is 64 system cycles and the quiet gap after the throw-away conversion is exactly 300 cycles, which can be counted at the pins. `TIMER_CYCLES` is cut to 1500 so that three timer-driven scans, each about 550 cycles long, fit in a short window without ever overlapping. A behavioural converter model inside the bench honours the start-bit rule, so the pipelined 16-clock spacing and the wake-up sequence are checked from the bytes the model actually decodes.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DUMMY = 2'd1,
      ST_WAIT  = 2'd2,
      ST_SCAN  = 2'd3
   } scan_state_e;

   // Power codes in the two low bits of a control byte
   localparam logic [1:0] PWR_KEEP  = 2'b11;
   localparam logic [1:0] PWR_SLEEP = 2'b01;

   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned SLOT_CLKS  = 16;
   localparam int unsigned DUMMY_CLKS = 24;

   // start | channel | unipolar | single-ended | power code
   function automatic logic [7:0] ctrl_byte(input logic [2:0] ch, input logic [1:0] pwr);
      return {1'b1, ch, 1'b1, 1'b1, pwr};
   endfunction

endpackage

// File: rtl/adc_scan_sclk.sv
module adc_scan_sclk #(
   parameter int unsigned HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic prd_end
);
   localparam int unsigned PRD  = 2 * HALF_DIV;
   localparam int unsigned PH_W = (PRD > 1) ? $clog2(PRD) : 1;

   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ph_q <= '0;
      else if (!run || ph_q == PH_W'(PRD - 1))      ph_q <= '0;
      else                                          ph_q <= ph_q + 1'b1;
   end

   // low half first, high half second; period ends as the clock falls
   assign sclk    = run && (ph_q >= PH_W'(HALF_DIV));
   assign prd_end = run && (ph_q == PH_W'(PRD - 1));
endmodule

// File: rtl/adc_scan_trig.sv
module adc_scan_trig #(
   parameter int unsigned TIMER_CYCLES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic timer_en,
   input  logic idle,
   output logic fire
);
   logic tick;

   generate
      if (TIMER_CYCLES == 0) begin : g_no_timer
         assign tick = 1'b0;
      end else begin : g_timer
         localparam int unsigned TW = $clog2(TIMER_CYCLES + 1);
         logic [TW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        cnt_q <= '0;
            else if (!timer_en || cnt_q == TW'(TIMER_CYCLES - 1)) cnt_q <= '0;
            else                                               cnt_q <= cnt_q + 1'b1;
         end
         assign tick = timer_en && (cnt_q == TW'(TIMER_CYCLES - 1));
      end
   endgenerate

   // requests outside the idle state are simply lost
   assign fire = idle && (start || tick);
endmodule

// File: rtl/adc_scan_ram.sv
module adc_scan_ram #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned WIDTH = 12,
   parameter int unsigned AW    = 3
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int unsigned N_CH         = 8,
   parameter int unsigned RES_W        = 12,
   parameter int unsigned HALF_DIV     = 2,
   parameter int unsigned WAKE_IDLE    = 75,
   parameter int unsigned TIMER_CYCLES = 50000,
   localparam int unsigned AW          = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             timer_en_i,
   input  logic             sleep_cfg_i,
   input  logic [AW-1:0]    rd_addr_i,
   output logic [RES_W-1:0] rd_data_o,
   output logic             scan_done_o,
   output logic             spi_sclk_o,
   output logic             spi_cs_n_o,
   output logic             spi_mosi_o,
   input  logic             spi_miso_i
);
   localparam int unsigned SCAN_LEN = SLOT_CLKS * (N_CH - 1) + DUMMY_CLKS;
   localparam int unsigned CAP_END  = BYTE_W + RES_W;
   localparam int unsigned K_MAX    = (SCAN_LEN > WAKE_IDLE) ? SCAN_LEN : WAKE_IDLE;
   localparam int unsigned KW       = $clog2(K_MAX + 1);

   generate
      if (N_CH < 2 || N_CH > 8) begin : g_bad_ch
         $error("N_CH must lie in 2..8");
      end
      if (RES_W < 2 || RES_W > 12) begin : g_bad_res
         $error("RES_W must lie in 2..12");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (WAKE_IDLE < 1) begin : g_bad_wake
         $error("WAKE_IDLE must be at least 1");
      end
   endgenerate

   scan_state_e      state_q;
   logic [KW-1:0]    k_q;
   logic [KW-1:0]    k_rel;
   logic [KW-1:0]    slot;
   logic [3:0]       bitpos;
   logic             sleep_q;
   logic             asleep_q;
   logic             done_q;
   logic [RES_W-1:0] shift_q;
   logic [7:0]       cur_byte;
   logic             in_frame;
   logic             gen_sclk;
   logic             prd_end;
   logic             fire;
   logic             ram_we;
   logic [AW-1:0]    ram_waddr;
   logic [RES_W-1:0] ram_wdata;

   adc_scan_sclk #(.HALF_DIV(HALF_DIV)) i_sclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q != ST_IDLE),
      .sclk    (gen_sclk),
      .prd_end (prd_end)
   );

   adc_scan_trig #(.TIMER_CYCLES(TIMER_CYCLES)) i_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_i),
      .timer_en (timer_en_i),
      .idle     (state_q == ST_IDLE),
      .fire     (fire)
   );

   adc_scan_ram #(.DEPTH(N_CH), .WIDTH(RES_W), .AW(AW)) i_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_waddr),
      .wdata (ram_wdata),
      .raddr (rd_addr_i),
      .rdata (rd_data_o)
   );

   // period index split into conversion slot and bit within slot
   assign slot   = k_q >> 4;
   assign bitpos = k_q[3:0];
   assign k_rel  = k_q - KW'(CAP_END);

   always_comb begin
      cur_byte = '0;
      if (state_q == ST_SCAN && slot < KW'(N_CH))
         cur_byte = ctrl_byte(slot[2:0],
                              (slot == KW'(N_CH - 1) && sleep_q) ? PWR_SLEEP : PWR_KEEP);
      else if (state_q == ST_DUMMY && slot == '0)
         cur_byte = ctrl_byte(3'd0, PWR_KEEP);
   end

   assign in_frame    = (state_q == ST_DUMMY) || (state_q == ST_SCAN);
   assign spi_cs_n_o  = !in_frame;
   assign spi_sclk_o  = gen_sclk && in_frame;
   assign spi_mosi_o  = (bitpos < 4'd8) && cur_byte[~bitpos[2:0]];
   assign scan_done_o = done_q;

   // last result bit of slot n is sampled at the end of period CAP_END+16n
   assign ram_we    = (state_q == ST_SCAN) && prd_end &&
                      (k_q >= KW'(CAP_END)) && (k_rel[3:0] == 4'd0);
   assign ram_waddr = AW'(k_rel >> 4);
   assign ram_wdata = {shift_q[RES_W-2:0], spi_miso_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         k_q      <= '0;
         sleep_q  <= 1'b0;
         asleep_q <= 1'b0;
         done_q   <= 1'b0;
         shift_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (fire) begin
                  sleep_q <= sleep_cfg_i;
                  k_q     <= '0;
                  state_q <= asleep_q ? ST_DUMMY : ST_SCAN;
               end
            end
            ST_DUMMY: begin
               if (prd_end) begin
                  if (k_q == KW'(DUMMY_CLKS - 1)) begin
                     k_q     <= '0;
                     state_q <= ST_WAIT;
                  end else begin
                     k_q <= k_q + 1'b1;
                  end
               end
            end
            ST_WAIT: begin
               if (prd_end) begin
                  if (k_q == KW'(WAKE_IDLE - 1)) begin
                     k_q      <= '0;
                     asleep_q <= 1'b0;
                     state_q  <= ST_SCAN;
                  end else begin
                     k_q <= k_q + 1'b1;
                  end
               end
            end
            ST_SCAN: begin
               if (prd_end) begin
                  shift_q <= {shift_q[RES_W-2:0], spi_miso_i};
                  if (k_q == KW'(SCAN_LEN - 1)) begin
                     state_q  <= ST_IDLE;
                     done_q   <= 1'b1;
                     asleep_q <= sleep_q;
                  end else begin
                     k_q <= k_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk (
   input logic clk,
   input logic rst_n,
   input logic scan_done_o,
   input logic spi_sclk_o,
   input logic spi_cs_n_o,
   input logic spi_mosi_o
);
   // R2: no clock edges outside a frame
   p_sclk_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n_o |-> !spi_sclk_o);

   // R2: data line parked low between frames
   p_mosi_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n_o |-> !spi_mosi_o);

   // R2: inside a frame data moves only with the falling clock
   p_mosi_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n_o && $past(!spi_cs_n_o) && !$stable(spi_mosi_o)) |-> $fell(spi_sclk_o));

   // R3: every frame opens with the start bit already on the line
   p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n_o) |-> spi_mosi_o);

   // R6: done is one cycle wide
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done_o |=> !scan_done_o);

   // R6: done coincides with the end of the frame
   p_done_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done_o |-> $rose(spi_cs_n_o));
endmodule

bind adc_scan_seq adc_scan_chk i_adc_scan_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scan_done_o (scan_done_o),
   .spi_sclk_o  (spi_sclk_o),
   .spi_cs_n_o  (spi_cs_n_o),
   .spi_mosi_o  (spi_mosi_o)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
   localparam int unsigned N_CH  = 8;
   localparam int unsigned RES_W = 12;
   localparam int unsigned HALF  = 2;
   localparam int unsigned WAKE  = 75;
   localparam int unsigned TIMER = 1500;
   localparam int          SCAN_RISES = 16 * N_CH + 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic timer_en = 1'b0;
   logic sleep_cfg = 1'b0;
   logic [2:0] rd_addr = '0;
   logic [RES_W-1:0] rd_data;
   logic scan_done, sclk, cs_n, mosi;
   logic miso;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk; // 20-unit period, 50 MHz with ns units

   adc_scan_seq #(.N_CH(N_CH), .RES_W(RES_W), .HALF_DIV(HALF),
                  .WAKE_IDLE(WAKE), .TIMER_CYCLES(TIMER)) i_adc_scan_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .timer_en_i(timer_en),
      .sleep_cfg_i(sleep_cfg), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .scan_done_o(scan_done), .spi_sclk_o(sclk), .spi_cs_n_o(cs_n),
      .spi_mosi_o(mosi), .spi_miso_i(miso));

   // ---------------- converter model ----------------
   int   seed = 0;
   logic [7:0] ctrl_log [256];
   int   ctrl_cnt = 0;
   int   frame_len [64];
   int   frame_cnt = 0;
   int   frame_rises = 0;
   logic [7:0] in_sr = '0;
   int   in_cnt = 0;
   bit   pend = 0;
   bit   conv_act = 0;
   int   out_idx = 0;
   logic [11:0] out_word = '0;
   logic dout = 1'b0;
   int   gap_run = 0;
   int   last_gap = 0;
   int   done_cnt = 0;

   function automatic logic [11:0] model_val(input int s, input int ch);
      return 12'((s * 397 + ch * 613 + 165) & 12'hFFF);
   endfunction

   assign miso = cs_n ? 1'b0 : dout;

   always @(posedge sclk, negedge sclk, posedge cs_n) begin
      if (cs_n === 1'b1) begin
         if (frame_rises > 0 && frame_cnt < 64) begin
            frame_len[frame_cnt] = frame_rises;
            frame_cnt++;
         end
         frame_rises = 0; in_cnt = 0; pend = 0; conv_act = 0; dout = 1'b0;
      end else if (sclk === 1'b1) begin
         frame_rises++;
         if (in_cnt > 0) begin
            in_sr = {in_sr[6:0], mosi};
            in_cnt++;
            if (in_cnt == 8) begin
               if (ctrl_cnt < 256) ctrl_log[ctrl_cnt] = in_sr;
               ctrl_cnt++;
               pend = 1; in_cnt = 0;
            end
         end else if (mosi === 1'b1 && (!conv_act || out_idx >= 7)) begin
            in_sr = 8'h01; in_cnt = 1;
         end
      end else if (sclk === 1'b0) begin
         if (pend) begin
            pend = 0; conv_act = 1; out_idx = 0;
            out_word = model_val(seed, int'(in_sr[6:4]));
            dout = 1'b0;
         end else if (conv_act) begin
            out_idx++;
            dout = (out_idx >= 1 && out_idx <= 12) ? out_word[12 - out_idx] : 1'b0;
         end
      end
   end

   always @(posedge clk) begin
      if (rst_n && scan_done === 1'b1) done_cnt++;
      if (cs_n === 1'b1) gap_run++;
      else if (gap_run > 0) begin last_gap = gap_run; gap_run = 0; end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_ctrl(input int ch, input int pwr);
      return 128 + ch * 16 + 12 + pwr;
   endfunction

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int t = 0;
      while (scan_done !== 1'b1 && t < 4000) begin @(negedge clk); t++; end
      chk(req, "scan_done seen", int'(scan_done === 1'b1), 1);
   endtask

   task automatic check_ram(input string req, input int s);
      for (int ch = 0; ch < N_CH; ch++) begin
         @(negedge clk) rd_addr = 3'(ch);
         #1 chk(req, $sformatf("result ch%0d", ch), int'(rd_data), int'(model_val(s, ch)));
      end
   endtask

   task automatic check_scan_bytes(input string req, input int base, input int last_pwr);
      for (int ch = 0; ch < N_CH; ch++)
         chk(req, $sformatf("ctrl byte ch%0d", ch), int'(ctrl_log[base + ch]),
             exp_ctrl(ch, (ch == N_CH - 1) ? last_pwr : 3));
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      #1 chk("R1", "cs_n in reset", int'(cs_n), 1);
      chk("R1", "sclk in reset", int'(sclk), 0);
      chk("R1", "mosi in reset", int'(mosi), 0);
      chk("R1", "done in reset", int'(scan_done), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1", "cs_n after reset", int'(cs_n), 1);
      chk("R2", "sclk idle low", int'(sclk), 0);
      chk("R1", "done after reset", int'(scan_done), 0);
   endtask

   task automatic t_scan_awake();
      int cb = ctrl_cnt; int fb = frame_cnt; int db = done_cnt;
      seed = 1; sleep_cfg = 1'b0;
      pulse_start();
      wait_done("R6");
      chk("R6", "cs_n high with done", int'(cs_n), 1);
      @(negedge clk);
      chk("R6", "done one cycle", int'(scan_done), 0);
      chk("R6", "done count", done_cnt - db, 1);
      chk("R4", "ctrl bytes in scan", ctrl_cnt - cb, N_CH);
      chk("R4", "frames in scan", frame_cnt - fb, 1);
      chk("R4", "scan frame length", frame_len[fb], SCAN_RISES);
      check_scan_bytes("R3", cb, 3);
      check_ram("R5", 1);
   endtask

   task automatic t_scan_sleep();
      int cb = ctrl_cnt; int fb = frame_cnt;
      seed = 2; sleep_cfg = 1'b1;
      pulse_start();
      wait_done("R7");
      @(negedge clk);
      chk("R7", "frames in sleep scan", frame_cnt - fb, 1);
      check_scan_bytes("R7", cb, 1);
      check_ram("R5", 2);
   endtask

   task automatic t_wake();
      int cb = ctrl_cnt; int fb = frame_cnt;
      seed = 3; sleep_cfg = 1'b0;
      pulse_start();
      wait_done("R8");
      @(negedge clk);
      chk("R8", "frames incl. wake-up", frame_cnt - fb, 2);
      chk("R8", "wake-up frame length", frame_len[fb], 24);
      chk("R8", "wake-up ctrl byte", int'(ctrl_log[cb]), exp_ctrl(0, 3));
      chk("R8", "quiet gap cycles", last_gap, WAKE * 2 * HALF);
      chk("R8", "scan frame after wake", frame_len[fb + 1], SCAN_RISES);
      check_scan_bytes("R8", cb + 1, 3);
      check_ram("R5", 3);
   endtask

   task automatic t_cfg_midscan();
      int cb = ctrl_cnt; int fb;
      seed = 4; sleep_cfg = 1'b0;
      pulse_start();
      repeat (100) @(negedge clk);
      sleep_cfg = 1'b1;
      wait_done("R9");
      chk("R9", "last byte keeps power", int'(ctrl_log[cb + N_CH - 1]), exp_ctrl(N_CH - 1, 3));
      fb = frame_cnt;
      @(negedge clk) sleep_cfg = 1'b0;
      pulse_start();
      wait_done("R9");
      @(negedge clk);
      chk("R9", "no wake-up frame", frame_cnt - fb, 1);
      chk("R9", "next frame is a scan", frame_len[fb], SCAN_RISES);
   endtask

   task automatic t_busy_drop();
      int fb = frame_cnt; int db = done_cnt;
      seed = 5; sleep_cfg = 1'b0;
      pulse_start();
      repeat (200) @(negedge clk);
      pulse_start();
      wait_done("R10");
      repeat (300) @(negedge clk);
      chk("R10", "busy trigger dropped: done", done_cnt - db, 1);
      chk("R10", "busy trigger dropped: frames", frame_cnt - fb, 1);
      chk("R10", "link idle after scan", int'(cs_n), 1);
      check_ram("R5", 5);
   endtask

   task automatic t_timer();
      int db = done_cnt;
      seed = 6;
      @(negedge clk) timer_en = 1'b1;
      repeat (3 * TIMER + 100) @(negedge clk);
      timer_en = 1'b0;
      repeat (800) @(negedge clk);
      chk("R10", "timer scans", done_cnt - db, 3);
      repeat (TIMER + 200) @(negedge clk);
      chk("R10", "timer off, no scans", done_cnt - db, 3);
   endtask

   initial begin : wd
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      t_reset();
      t_scan_awake();
      t_scan_sleep();
      t_wake();
      t_cfg_midscan();
      t_busy_drop();
      t_timer();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule